// File: doc/BRIEF.md
# Fractional Multiply-Accumulate-Round Unit

This datapath takes two signed 24-bit fractional operands, forms their product and either adds it to or subtracts it from a 56-bit accumulator value supplied with the operands. The accumulator is organised as an 8-bit extension (bits 55:48), a 24-bit high word (bits 47:24) and a 24-bit low word (bits 23:0). The binary point sits between bits 47 and 46. The sum is then rounded half-to-even at a bit position chosen by a 2-bit scaling mode, and the low word of the returned accumulator is always zero.

A second operand form replaces the product with one operand scaled by 2^-n, where n is a 5-bit immediate. That term goes through the same add/subtract and rounding path.

The unit accepts one operation per clock, marked by `in_valid`. Each result appears two clocks later with `out_valid`. The first stage builds the term and the second accumulates and rounds. Between results the output register keeps its last value.

Top module: `fmac_round`

## Requirements
- R1: With `term_sel`=0 and `sub_sel`=0, `acc_out` equals `acc_in` plus the signed product `op_a`*`op_b` shifted left by one bit and sign-extended to 56 bits, modulo 2^56, before rounding.
- R2: With `sub_sel`=1, the term is subtracted from `acc_in` instead of added, modulo 2^56.
- R3: Rounding at position k adds 2^k to the sum and clears bits k:0. When bits k:0 of the sum equal exactly 2^k, bit k+1 of the result is also cleared, so an exact half goes to the even neighbour.
- R4: `scale_mode` encoding sets k: 2'b00 gives k=23, 2'b01 gives k=24, 2'b10 gives k=22, and 2'b11 behaves exactly like 2'b00.
- R5: Every valid result has `acc_out[23:0]` equal to zero.
- R6: With `term_sel`=1, the term is `op_a` sign-extended and placed at bits 47:24, then arithmetically shifted right by `shift_n`. `op_b` has no effect.
- R7: Each cycle with `in_valid`=1 produces `out_valid`=1 exactly two clock edges later, and `out_valid` is never 1 otherwise. Back-to-back inputs give back-to-back results.
- R8: A synchronous active-high `rst` clears `out_valid` and `acc_out` to zero at the next edge.
- R9: While `out_valid` is 0, `acc_out` keeps the last result, or zero after reset.
- R10: `shift_n` values of 24 to 31 act as 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe, one per operation |
| op_a | input | 24 | First signed fractional operand |
| op_b | input | 24 | Second signed fractional operand (product form only) |
| sub_sel | input | 1 | 1 subtracts the term, 0 adds it |
| term_sel | input | 1 | 0 product form, 1 power-of-two form |
| shift_n | input | 5 | Right shift count for the power-of-two form |
| acc_in | input | 56 | Accumulator value to update |
| scale_mode | input | 2 | Rounding position select |
| out_valid | output | 1 | Result strobe |
| acc_out | output | 56 | Rounded accumulator result |

## Verification
A wrong rounding position or a missed tie shows in the very result that carries it, two cycles after the input. It appears as a high word off by one unit, or as an odd value where an exact half should have landed on an even one. A broken valid pipeline shows as a strobe arriving a cycle early or late, or as a result overwriting the held value during idle cycles. Subtraction or extension errors show as wrong sign bits in bits 55:48 on the same result. Random accumulators with all four scaling modes reach ties only rarely, so directed exact-half cases are mixed in.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

  typedef enum logic [1:0] {
    SCL_NONE = 2'b00,
    SCL_DOWN = 2'b01,
    SCL_UP   = 2'b10,
    SCL_RSVD = 2'b11
  } scale_mode_e;

  // Index of the rounding candidate: 0 -> one bit below the word
  // boundary, 1 -> on the boundary, 2 -> one bit above it.
  function automatic logic [1:0] pos_index(input scale_mode_e m);
    case (m)
      SCL_UP:   return 2'd0;
      SCL_DOWN: return 2'd2;
      default:  return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/fmac_term_gen.sv
module fmac_term_gen #(
  parameter int DATA_W = 24,
  parameter int EXT_W  = 8,
  parameter int SH_W   = 5,
  localparam int ACC_W = EXT_W + 2 * DATA_W
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              term_sel,
  input  logic [SH_W-1:0]   shift_n,
  output logic [ACC_W-1:0]  term
);

  localparam logic [SH_W-1:0] SH_MAX = SH_W'(DATA_W - 1);

  // Fractional product: signed full product, doubled, sign-extended.
  function automatic logic [ACC_W-1:0] frac_mul(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    logic signed [2*DATA_W-1:0] p;
    logic signed [ACC_W-1:0]    p_ext;
    p     = $signed(a) * $signed(b);
    p_ext = ACC_W'(p);
    p_ext = p_ext <<< 1;
    return p_ext;
  endfunction

  // Power-of-two term: operand at the high word, arithmetic right shift.
  function automatic logic [ACC_W-1:0] pow2_term(input logic [DATA_W-1:0] a,
                                                 input logic [SH_W-1:0]   n);
    logic signed [ACC_W-1:0] placed;
    placed = ACC_W'($signed(a));
    placed = placed <<< DATA_W;
    return placed >>> n;
  endfunction

  logic [SH_W-1:0]  n_eff;
  logic [ACC_W-1:0] mul_term;
  logic [ACC_W-1:0] shf_term;

  always_comb begin
    n_eff    = (shift_n > SH_MAX) ? SH_MAX : shift_n;
    mul_term = frac_mul(op_a, op_b);
    shf_term = pow2_term(op_a, n_eff);
    term     = term_sel ? shf_term : mul_term;
  end

endmodule

// File: rtl/fmac_accum.sv
module fmac_accum #(
  parameter int ACC_W = 56
) (
  input  logic [ACC_W-1:0] acc_in,
  input  logic [ACC_W-1:0] term,
  input  logic             sub_sel,
  output logic [ACC_W-1:0] sum
);

  function automatic logic [ACC_W-1:0] add_sub(input logic [ACC_W-1:0] x,
                                               input logic [ACC_W-1:0] t,
                                               input logic             neg);
    logic [ACC_W-1:0] t_eff;
    t_eff = neg ? ~t : t;
    return x + t_eff + ACC_W'(neg);
  endfunction

  assign sum = add_sub(acc_in, term, sub_sel);

endmodule

// File: rtl/fmac_rounder.sv
module fmac_rounder
  import fmac_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 56,
  parameter int POS_W  = 6
) (
  input  logic [ACC_W-1:0]  sum,
  input  scale_mode_e       mode,
  output logic [ACC_W-1:0]  rounded,
  output logic              tie,
  output logic [POS_W-1:0]  pos
);

  localparam int N_CAND = 3;
  localparam int POS_LO = DATA_W - 2;

  logic [ACC_W-1:0] cand_val [N_CAND];
  logic             cand_tie [N_CAND];

  for (genvar g = 0; g < N_CAND; g++) begin : g_cand
    localparam int P = POS_LO + g;
    localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << P;
    localparam logic [ACC_W-1:0] KEEP = {{(ACC_W-P-1){1'b1}}, {(P+1){1'b0}}};
    localparam logic [ACC_W-1:0] EVEN = ~(ACC_W'(1) << (P + 1));
    localparam logic [ACC_W-1:0] LOWZ = {{(ACC_W-DATA_W){1'b1}}, {DATA_W{1'b0}}};

    logic             half_hit;
    logic [ACC_W-1:0] bumped;

    always_comb begin
      half_hit    = ((sum & ~KEEP) == HALF);
      bumped      = (sum + HALF) & KEEP;
      if (half_hit) bumped = bumped & EVEN;
      cand_val[g] = bumped & LOWZ;
      cand_tie[g] = half_hit;
    end
  end

  logic [1:0] sel;

  always_comb begin
    sel     = pos_index(mode);
    rounded = cand_val[1];
    tie     = cand_tie[1];
    for (int i = 0; i < N_CAND; i++) begin
      if (sel == 2'(i)) begin
        rounded = cand_val[i];
        tie     = cand_tie[i];
      end
    end
    pos = POS_W'(POS_LO) + POS_W'(sel);
  end

endmodule

// File: rtl/fmac_round.sv
module fmac_round
  import fmac_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int EXT_W  = 8,
  parameter int SH_W   = 5,
  localparam int ACC_W = EXT_W + 2 * DATA_W,
  localparam int POS_W = $clog2(ACC_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              sub_sel,
  input  logic              term_sel,
  input  logic [SH_W-1:0]   shift_n,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic [1:0]        scale_mode,
  output logic              out_valid,
  output logic [ACC_W-1:0]  acc_out
);

  // Stage 1: term generation
  logic [ACC_W-1:0] term_c;

  fmac_term_gen #(
    .DATA_W(DATA_W),
    .EXT_W (EXT_W),
    .SH_W  (SH_W)
  ) u_term (
    .op_a    (op_a),
    .op_b    (op_b),
    .term_sel(term_sel),
    .shift_n (shift_n),
    .term    (term_c)
  );

  logic             s1_valid;
  logic [ACC_W-1:0] s1_term;
  logic [ACC_W-1:0] s1_acc;
  logic             s1_sub;
  scale_mode_e      s1_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
    end
    if (in_valid) begin
      s1_term <= term_c;
      s1_acc  <= acc_in;
      s1_sub  <= sub_sel;
      s1_mode <= scale_mode_e'(scale_mode);
    end
  end

  // Stage 2: accumulate and round
  logic [ACC_W-1:0] sum_c;
  logic [ACC_W-1:0] rnd_c;
  logic             tie_c;
  logic [POS_W-1:0] pos_c;

  fmac_accum #(.ACC_W(ACC_W)) u_acc (
    .acc_in (s1_acc),
    .term   (s1_term),
    .sub_sel(s1_sub),
    .sum    (sum_c)
  );

  fmac_rounder #(
    .DATA_W(DATA_W),
    .ACC_W (ACC_W),
    .POS_W (POS_W)
  ) u_rnd (
    .sum    (sum_c),
    .mode   (s1_mode),
    .rounded(rnd_c),
    .tie    (tie_c),
    .pos    (pos_c)
  );

  // Observation registers for the checker
  logic             tie_q;
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
      tie_q     <= 1'b0;
      pos_q     <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        acc_out <= rnd_c;
        tie_q   <= tie_c;
        pos_q   <= pos_c;
      end
    end
  end

endmodule

// File: rtl/fmac_round_chk.sv
module fmac_round_chk #(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 56,
  parameter int POS_W  = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             s1_valid,
  input logic             out_valid,
  input logic             tie_q,
  input logic [POS_W-1:0] pos_q,
  input logic [ACC_W-1:0] acc_out
);

  AST_STAGE1_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid); // R7

  AST_STAGE2_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid); // R7

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(s1_valid)); // R7

  AST_LOW_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (acc_out[DATA_W-1:0] == '0)); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(acc_out)); // R9

  AST_TIE_EVEN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && tie_q && (int'(pos_q) >= DATA_W - 1))
      |-> (acc_out[int'(pos_q) + 1] == 1'b0)); // R3

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && (acc_out == '0))); // R8

endmodule

bind fmac_round fmac_round_chk #(
  .DATA_W(DATA_W),
  .ACC_W (ACC_W),
  .POS_W (POS_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .s1_valid (s1_valid),
  .out_valid(out_valid),
  .tie_q    (tie_q),
  .pos_q    (pos_q),
  .acc_out  (acc_out)
);

// File: tb/fmac_round_bench.sv
module fmac_round_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [23:0] op_a = '0;
  logic [23:0] op_b = '0;
  logic        sub_sel = 1'b0;
  logic        term_sel = 1'b0;
  logic [4:0]  shift_n = '0;
  logic [55:0] acc_in = '0;
  logic [1:0]  scale_mode = '0;
  logic        out_valid;
  logic [55:0] acc_out;

  always #5 clk = ~clk;

  fmac_round u_fmac_round (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sub_sel(sub_sel), .term_sel(term_sel), .shift_n(shift_n),
    .acc_in(acc_in), .scale_mode(scale_mode),
    .out_valid(out_valid), .acc_out(acc_out)
  );

  int          n_tests = 0;
  int          n_fail  = 0;
  bit          prev_v  = 1'b0;
  logic [55:0] prev_exp = '0;
  string       prev_tag = "";
  logic [55:0] last_res = '0;

  // Reference: floor-quotient form of half-to-even rounding.
  function automatic logic [55:0] model(input logic [23:0] a, input logic [23:0] b,
                                        input logic ng, input logic sf,
                                        input logic [4:0] n, input logic [55:0] acc,
                                        input logic [1:0] sc);
    longint      t;
    int          nn;
    int          k;
    logic [55:0] s, q, r, half, res;
    nn = (n > 5'd23) ? 23 : int'(n);
    if (sf) t = (longint'($signed(a)) * (longint'(1) << 24)) >>> nn;
    else    t = longint'($signed(a)) * longint'($signed(b)) * 2;
    s = ng ? acc - t[55:0] : acc + t[55:0];
    k = (sc == 2'b01) ? 24 : (sc == 2'b10) ? 22 : 23;
    q = s >> (k + 1);
    r = s & ((56'd1 << (k + 1)) - 56'd1);
    half = 56'd1 << k;
    if (r > half) q = q + 56'd1;
    else if (r == half && q[0]) q = q + 56'd1;
    res = q << (k + 1);
    res[23:0] = '0;
    return res;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [55:0] act,
                     input logic [55:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_out();
    if (prev_v) begin
      chk(out_valid == 1'b1, "R7", 56'(out_valid), 56'd1);
      chk(acc_out == prev_exp, prev_tag, acc_out, prev_exp);
      chk(acc_out[23:0] == 24'd0, "R5", 56'(acc_out[23:0]), 56'd0);
      last_res = acc_out;
    end else begin
      chk(out_valid == 1'b0, "R7", 56'(out_valid), 56'd0);
      chk(acc_out == last_res, "R9", acc_out, last_res);
    end
  endtask

  task automatic drive(input logic v, input logic [23:0] a, input logic [23:0] b,
                       input logic ng, input logic sf, input logic [4:0] n,
                       input logic [55:0] acc, input logic [1:0] sc,
                       input string tag);
    in_valid = v; op_a = a; op_b = b; sub_sel = ng; term_sel = sf;
    shift_n = n; acc_in = acc; scale_mode = sc;
    @(negedge clk);
    check_out();
    prev_v   = v;
    prev_exp = v ? model(a, b, ng, sf, n, acc, sc) : '0;
    prev_tag = tag;
  endtask

  task automatic idle();
    drive(1'b0, '0, '0, 1'b0, 1'b0, '0, '0, 2'b00, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8", 56'(out_valid), 56'd0);
    chk(acc_out == '0, "R8", acc_out, 56'd0);
    rst = 1'b0;

    // R1: 0.5 * 0.5 and -1 * -1 (extension bits)
    drive(1'b1, 24'h400000, 24'h400000, 1'b0, 1'b0, 5'd0, 56'd0, 2'b00, "R1");
    drive(1'b1, 24'h800000, 24'h800000, 1'b0, 1'b0, 5'd0, 56'd0, 2'b00, "R1");
    // R2: subtract
    drive(1'b1, 24'h800000, 24'h800000, 1'b1, 1'b0, 5'd0, 56'd0, 2'b00, "R2");
    drive(1'b1, 24'h123456, 24'h654321, 1'b1, 1'b0, 5'd0, 56'h00_100000_000000, 2'b00, "R2");
    idle();
    // R3: exact half odd -> up, even -> stays, above half -> up
    drive(1'b1, 24'h0, 24'h0, 1'b0, 1'b0, 5'd0, 56'h00_000001_800000, 2'b00, "R3");
    drive(1'b1, 24'h0, 24'h0, 1'b0, 1'b0, 5'd0, 56'h00_000002_800000, 2'b00, "R3");
    drive(1'b1, 24'h0, 24'h0, 1'b0, 1'b0, 5'd0, 56'h00_000002_800001, 2'b00, "R3");
    drive(1'b1, 24'h0, 24'h0, 1'b0, 1'b0, 5'd0, 56'hFF_FFFFFF_800000, 2'b00, "R3");
    // R4: each scaling mode
    drive(1'b1, 24'h0, 24'h0, 1'b0, 1'b0, 5'd0, 56'h00_000003_000000, 2'b01, "R4");
    drive(1'b1, 24'h0, 24'h0, 1'b0, 1'b0, 5'd0, 56'h00_000001_000000, 2'b01, "R4");
    drive(1'b1, 24'h0, 24'h0, 1'b0, 1'b0, 5'd0, 56'h00_000001_C00000, 2'b10, "R4");
    drive(1'b1, 24'h0, 24'h0, 1'b0, 1'b0, 5'd0, 56'h00_000001_800000, 2'b11, "R4");
    idle();
    idle();
    // R6: power-of-two form, op_b ignored; R10: clamp
    drive(1'b1, 24'h400000, 24'hABCDEF, 1'b0, 1'b1, 5'd0, 56'd0, 2'b00, "R6");
    drive(1'b1, 24'h400000, 24'h123456, 1'b0, 1'b1, 5'd4, 56'd0, 2'b00, "R6");
    drive(1'b1, 24'h800000, 24'h777777, 1'b0, 1'b1, 5'd31, 56'd0, 2'b00, "R10");
    drive(1'b1, 24'h7FFFFF, 24'h000001, 1'b1, 1'b1, 5'd24, 56'd0, 2'b00, "R10");

    // R8: reset mid-stream
    drive(1'b1, 24'h400000, 24'h400000, 1'b0, 1'b0, 5'd0, 56'd0, 2'b00, "R1");
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", 56'(out_valid), 56'd0);
    chk(acc_out == '0, "R8", acc_out, 56'd0);
    rst = 1'b0;
    prev_v = 1'b0;
    last_res = '0;

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic        v, ng, sf;
      logic [4:0]  n;
      logic [1:0]  sc;
      logic [55:0] acc;
      string       tag;
      v   = ($urandom % 4) != 0;
      ng  = $urandom % 2;
      sf  = ($urandom % 4) == 0;
      n   = 5'($urandom);
      sc  = 2'($urandom);
      acc = {24'($urandom), 32'($urandom)};
      if ($urandom % 2) acc[55:48] = {8{acc[47]}};
      if ($urandom % 8 == 0) acc[22:0] = '0;
      tag = sf ? "R6" : (ng ? "R2" : "R1");
      drive(v, 24'($urandom), 24'($urandom), ng, sf, n, acc, sc, tag);
    end
    idle();
    idle();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule